// File: doc/BRIEF.md
# Text Screen Display-Memory Address Sequencer

This block generates the display-memory address for a character terminal that shows 12 rows of 80 characters. Three cascaded counters produce the address. A character counter counts to 20 and carries into a block counter that counts to 4, so together they step across the 80 characters of a row. A row counter counts to 12 and moves forward once per character row. It is advanced by one bit of the scan-line counter that drives the character generator. The raw counter fields are combined into a dense linear address, `row*80 + block*20 + char`. Codes 960 to 1023 never appear on the scan address.

A cursor register holds the location where the next character will be written. Its value is compared against the live scan address, and a hit flag is raised when the two match, so that the video path can draw the cursor. A 1K x 8 memory model is included. It is addressed by the scan address and uses an active-low chip select and an active-low write enable. A write completes when write enable rises.

Top module: `scr_addr_seq`

## Requirements
- R1: While `rst` is high at a clock edge, the character, block and row counters and the cursor all clear to 0, so `scan_addr` and `cursor` read 0 after that edge.
- R2: Each clock with `char_tick` high advances the character counter. After character 19 it returns to 0 and the block counter advances. After block 3 the block counter returns to 0, so the address goes back to the start of the same row. `scan_addr` always equals row*80 + block*20 + char, and it holds its value on clocks with no character step and no row step.
- R3: The row counter advances by one on each clock in which `scan_row_bit` is low and was high at the previous clock edge (a falling edge). After row 11 it returns to 0. A row step and a character step in the same clock both take effect.
- R4: `scan_addr` never exceeds 959, and every address from 0 to 959 is produced by a full sweep of the screen.
- R5: `cur_load` has priority over `cur_inc`, and `cur_inc` has priority over `cur_dec`. A load takes `cur_load_val` only when that value is below 960. A load of 960 or more leaves the cursor unchanged and also blocks any increment or decrement in that clock.
- R6: Increment moves the cursor from 959 to 0. Decrement moves it from 0 to 959. Otherwise each steps by one.
- R7: `cursor_hit` is high exactly when `scan_addr` equals `cursor`.
- R8: A read is active when `cs_n` is 0 and `we_n` is 1. During a read, `rd_valid` is 1 and `rdata` shows the byte stored at `scan_addr`. At all other times `rd_valid` is 0 and `rdata` is 0.
- R9: A write stores `wdata` at `scan_addr` on a clock where `we_n` is 1, `we_n` was 0 at the previous clock edge, and `cs_n` is 0. When `cs_n` is 1 during that rising edge of `we_n`, the memory is not changed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| char_tick | input | 1 | Character-time step pulse |
| scan_row_bit | input | 1 | Scan-line counter bit; its falling edge advances the row |
| cur_load | input | 1 | Load cursor from `cur_load_val` |
| cur_load_val | input | 10 | Cursor load value |
| cur_inc | input | 1 | Step cursor forward |
| cur_dec | input | 1 | Step cursor back |
| cs_n | input | 1 | Memory select, active low |
| we_n | input | 1 | Memory write enable, active low |
| wdata | input | 8 | Write data |
| scan_addr | output | 10 | Linear display address |
| cursor | output | 10 | Cursor location |
| cursor_hit | output | 1 | Scan address equals cursor |
| rd_valid | output | 1 | Read data is being driven |
| rdata | output | 8 | Read data, 0 when not reading |

## Verification
The bench sweeps all 12 rows through two frames, using a falling edge of the scan bit between rows. This shows that a counter with a wrong terminal count, or a bad fold, either skips an address or produces one above 959. Both are caught by the coverage check and the per-cycle address compare. It fills memory across the whole screen and then issues random writes. Some of these writes raise `we_n` with the select off, so a design that writes without select, or writes on the falling edge of `we_n`, returns bytes that do not match the model. Random cursor traffic includes out-of-range loads and both wrap points, and forces a hit at a known address. An off-by-one wrap, wrong priority, or acceptance of a bad load shows up as a cursor or hit mismatch.

// File: rtl/scr_addr_seq.sv
module scr_addr_seq #(
  parameter int CHARS_PER_BLK = 20,
  parameter int BLKS_PER_ROW  = 4,
  parameter int ROWS          = 12,
  parameter int AW            = 10,
  parameter int DW            = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          char_tick,
  input  logic          scan_row_bit,
  input  logic          cur_load,
  input  logic [AW-1:0] cur_load_val,
  input  logic          cur_inc,
  input  logic          cur_dec,
  input  logic          cs_n,
  input  logic          we_n,
  input  logic [DW-1:0] wdata,
  output logic [AW-1:0] scan_addr,
  output logic [AW-1:0] cursor,
  output logic          cursor_hit,
  output logic          rd_valid,
  output logic [DW-1:0] rdata
);
  localparam int CW      = $clog2(CHARS_PER_BLK);
  localparam int BW      = $clog2(BLKS_PER_ROW);
  localparam int RW      = $clog2(ROWS);
  localparam int ROW_LEN = CHARS_PER_BLK * BLKS_PER_ROW;
  localparam int SCREEN  = ROW_LEN * ROWS;
  localparam int DEPTH   = 1 << AW;

  logic [CW-1:0] chr_q;
  logic [BW-1:0] blk_q;
  logic [RW-1:0] row_q;
  logic          sbit_q;
  logic          we_q;
  logic [DW-1:0] mem [DEPTH];

  wire chr_last = chr_q == CW'(CHARS_PER_BLK - 1);
  wire blk_last = blk_q == BW'(BLKS_PER_ROW - 1);
  wire row_last = row_q == RW'(ROWS - 1);
  wire row_step = sbit_q & ~scan_row_bit;
  wire [AW-1:0] cur_top = AW'(SCREEN - 1);
  wire load_ok = cur_load_val < AW'(SCREEN);
  wire write_fire = ~we_q & we_n & ~cs_n;

  assign scan_addr = AW'(row_q) * AW'(ROW_LEN)
                   + AW'(blk_q) * AW'(CHARS_PER_BLK)
                   + AW'(chr_q);
  assign cursor_hit = scan_addr == cursor;
  assign rd_valid = ~cs_n & we_n;
  assign rdata = rd_valid ? mem[scan_addr] : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      chr_q  <= '0;
      blk_q  <= '0;
      row_q  <= '0;
      sbit_q <= 1'b0;
      we_q   <= 1'b1;
    end else begin
      sbit_q <= scan_row_bit;
      we_q   <= we_n;
      if (char_tick) begin
        if (chr_last) begin
          chr_q <= '0;
          blk_q <= blk_last ? '0 : blk_q + BW'(1);
        end else begin
          chr_q <= chr_q + CW'(1);
        end
      end
      if (row_step) row_q <= row_last ? '0 : row_q + RW'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) cursor <= '0;
    else if (cur_load) begin
      if (load_ok) cursor <= cur_load_val;
    end else if (cur_inc) cursor <= (cursor == cur_top) ? '0 : cursor + AW'(1);
    else if (cur_dec) cursor <= (cursor == '0) ? cur_top : cursor - AW'(1);
  end

  always_ff @(posedge clk) begin
    if (write_fire) mem[scan_addr] <= wdata;
  end

  AST_ADDR_RANGE: assert property (@(posedge clk) disable iff (rst) scan_addr < AW'(SCREEN)); // R4
  AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!char_tick && !row_step) |=> $stable(scan_addr)); // R2
  AST_CUR_RANGE: assert property (@(posedge clk) disable iff (rst) cursor < AW'(SCREEN)); // R5
  AST_INC_WRAP: assert property (@(posedge clk) disable iff (rst)
    (!cur_load && cur_inc && cursor == cur_top) |=> cursor == '0); // R6
  AST_DEC_WRAP: assert property (@(posedge clk) disable iff (rst)
    (!cur_load && !cur_inc && cur_dec && cursor == '0) |=> cursor == cur_top); // R6
  AST_BAD_LOAD: assert property (@(posedge clk) disable iff (rst)
    (cur_load && !load_ok) |=> $stable(cursor)); // R5
  AST_READ_OFF: assert property (@(posedge clk) disable iff (rst)
    cs_n |-> (!rd_valid && rdata == '0)); // R8
endmodule

// File: tb/scr_addr_seq_bench.sv
module scr_addr_seq_bench;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic char_tick = 1'b0, scan_row_bit = 1'b0;
  logic cur_load = 1'b0, cur_inc = 1'b0, cur_dec = 1'b0;
  logic [9:0] cur_load_val = '0;
  logic cs_n = 1'b1, we_n = 1'b1;
  logic [7:0] wdata = '0;
  logic [9:0] scan_addr, cursor;
  logic cursor_hit, rd_valid;
  logic [7:0] rdata;

  scr_addr_seq u_scr_addr_seq (.*);

  always #5 clk = ~clk;

  int errs = 0, checks = 0, hits = 0;
  int m_chr = 0, m_blk = 0, m_row = 0, m_cur = 0;
  bit m_sq = 0, m_wq = 1;
  int mem [1024];
  bit written [1024];
  bit seen [960];
  bit done = 0;

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errs++;
      $display("FAIL %s: actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    int a;
    a = m_row * 80 + m_blk * 20 + m_chr;
    if (rst) begin
      m_chr = 0; m_blk = 0; m_row = 0; m_cur = 0; m_sq = 0; m_wq = 1;
    end else begin
      if (!m_wq && we_n && !cs_n) begin mem[a] = wdata; written[a] = 1; end
      if (char_tick) begin
        m_chr++;
        if (m_chr == 20) begin m_chr = 0; m_blk = (m_blk + 1) % 4; end
      end
      if (m_sq && !scan_row_bit) m_row = (m_row + 1) % 12;
      if (cur_load) begin
        if (cur_load_val < 960) m_cur = cur_load_val;
      end else if (cur_inc) m_cur = (m_cur == 959) ? 0 : m_cur + 1;
      else if (cur_dec) m_cur = (m_cur == 0) ? 959 : m_cur - 1;
      m_sq = scan_row_bit;
      m_wq = we_n;
    end
    #2;
    a = m_row * 80 + m_blk * 20 + m_chr;
    if (rst) begin
      chk("R1 addr", scan_addr, 0);
      chk("R1 cursor", cursor, 0);
    end else begin
      chk("R2/R3 scan_addr", scan_addr, a);
      chk("R5/R6 cursor", cursor, m_cur);
      chk("R7 cursor_hit", cursor_hit, a == m_cur);
      chk("R8 rd_valid", rd_valid, !cs_n && we_n);
      if (!(!cs_n && we_n)) chk("R8 rdata idle", rdata, 0);
      else if (written[a]) chk("R9 rdata", rdata, mem[a]);
      if (a < 960) seen[a] = 1;
      if (a == m_cur) hits++;
    end
  end

  task automatic cyc(); @(negedge clk); endtask

  task automatic row_pulse();
    scan_row_bit = 1; cyc();
    scan_row_bit = 0; cyc();
  endtask

  initial begin
    repeat (3) cyc();
    rst = 0;
    // R2 R3 R4: two full frames, cursor parked at 85 for R7
    cur_load = 1; cur_load_val = 10'd85; cyc(); cur_load = 0;
    for (int f = 0; f < 2; f++)
      for (int r = 0; r < 12; r++) begin
        for (int c = 0; c < 80; c++) begin char_tick = 1; cyc(); end
        char_tick = 0;
        row_pulse();
      end
    begin
      int miss = 0;
      for (int i = 0; i < 960; i++) if (!seen[i]) miss++;
      chk("R4 unvisited addresses", miss, 0);
    end
    // R9 fill every screen location
    cs_n = 0;
    for (int k = 0; k < 960; k++) begin
      wdata = 8'(k * 7 + 3); we_n = 0; cyc();
      we_n = 1; cyc();
      char_tick = 1; cyc(); char_tick = 0;
      if (k % 80 == 79) row_pulse();
    end
    // R5 R6: wrap corners and bad load
    cur_load = 1; cur_load_val = 10'd959; cyc();
    cur_load = 0; cur_inc = 1; cyc(); cur_inc = 0;
    cur_dec = 1; cyc(); cur_dec = 0;
    cur_load = 1; cur_load_val = 10'd1000; cur_inc = 1; cyc();
    cur_load = 0; cur_inc = 0; cyc();
    // random traffic over all inputs
    for (int i = 0; i < 8000; i++) begin
      int r = $urandom % 100;
      char_tick = r < 60;
      if ($urandom % 40 == 0) scan_row_bit = ~scan_row_bit;
      cur_load = ($urandom % 20) == 0;
      cur_load_val = 10'($urandom % 1024);
      cur_inc = ($urandom % 4) == 0;
      cur_dec = ($urandom % 4) == 0;
      cs_n = ($urandom % 3) == 0;
      we_n = ($urandom % 3) != 0;
      wdata = 8'($urandom);
      cyc();
    end
    chk("R7 hit observed", hits > 0, 1);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    #1000000;
    if (!done) begin
      errs++; checks++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end
endmodule